// File: doc/BRIEF.md
# PCI Error Header Log Capture

This block watches a conventional parallel PCI bus and records the address and command of the transaction that was most recently flagged as bad. On every address phase it stages the bus address and the command code in a shadow record. A dual-address cycle adds its second address phase to that record. When the error-detected strobe is raised for the current transaction, the shadow record is copied into a 128-bit read-only log.

Software reads the log as four 32-bit dwords through a registered configuration-read port. The log holds the address halves and the two command codes. The reserved and attribute fields always read as zero, because no attribute phase exists. A clean transaction leaves the log alone, and each new error replaces the old entry. Any one of three active-low reset sources (link, global, power-on) clears the log.

Top module: `pci_err_hdr_log`

## Requirements
- R1: The first address phase is the clock on which FRAME# is low after a clock on which it was high. On that phase, AD is staged for log bits 95:64 (dword 2) and C/BE# for bits 39:36 (dword 1, bits 7:4).
- R2: If C/BE# in the first address phase equals 4'b1101 (dual-address cycle), the following clock is the second address phase. Its AD is staged for bits 127:96 (dword 3) and its C/BE# for bits 43:40 (dword 1, bits 11:8).
- R3: A transaction whose first-phase command is not 4'b1101 stages zero into bits 127:96 and into bits 43:40.
- R4: Bits 35:0 and 63:44 always read zero. Dword 0 is always zero, and dword 1 bits 31:12 and 3:0 are always zero.
- R5: The log changes only on a clock where err_strobe is high. On that clock it takes the staged record, which replaces any earlier entry. Transactions without the strobe leave the log unchanged.
- R6: A strobe on the same clock as an address phase logs the record including that phase.
- R7: With rd_en high, rd_addr (a dword index) equal to BASE_DW+0, +1, +2 or +3 returns log bits 31:0, 63:32, 95:64 or 127:96 respectively. Any other rd_addr returns zero.
- R8: rd_data is registered. It shows the selected dword one clock after rd_en and holds while rd_en is low. A read on the clock of a log update returns the updated value.
- R9: Asserting link_rst_n, glob_rst_n or por_rst_n (low) clears the log, the staged record and rd_data to zero.
- R10: While FRAME# stays low after the address phases, no further AD or C/BE# value is staged. A new first address phase needs FRAME# high for at least one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI bus clock |
| link_rst_n | input | 1 | Link reset, active low |
| glob_rst_n | input | 1 | Global reset, active low |
| por_rst_n | input | 1 | Power-on reset, active low |
| frame_n | input | 1 | Bus FRAME#, active low |
| ad | input | AD_W (32) | Bus address/data lines |
| cbe_n | input | CBE_W (4) | Bus command/byte-enable lines, recorded as driven |
| err_strobe | input | 1 | Error detected for the current transaction |
| rd_en | input | 1 | Configuration read request |
| rd_addr | input | ADDR_W (10) | Dword index of the configuration read |
| rd_data | output | 32 | Read data, valid the clock after rd_en |

## Verification
Address phases are staged at the clock edge that ends them. A strobe makes the log take that record at the edge that ends the strobe cycle. Read data appears at the edge after the rd_en cycle. The bench drives every input on the falling clock edge and samples rd_data on the next falling edge, so each result is read half a cycle after the rising edge that must produce it. Every log check goes through a full four-dword readback. A check for a read on the same clock as an update sets rd_en in the strobe cycle itself, so the bypass path is tested at the exact edge.

// File: rtl/pci_hdr_log_pkg.sv
package pci_hdr_log_pkg;

   localparam int unsigned LOG_DWORDS = 4;
   localparam logic [3:0]  CMD_DUAL_ADDR = 4'b1101;

   typedef enum logic [1:0] {
      TRK_IDLE = 2'd0,
      TRK_DAC2 = 2'd1,
      TRK_BUSY = 2'd2
   } trk_state_t;

   // Builds one visible dword of the 128-bit log from its stored fields.
   function automatic logic [31:0] lane_word(input logic [1:0]  idx,
                                             input logic [31:0] lo,
                                             input logic [31:0] hi,
                                             input logic [3:0]  cl,
                                             input logic [3:0]  ch);
      logic [31:0] w;
      case (idx)
         2'd0:    w = '0;
         2'd1:    w = {20'h0, ch, cl, 4'h0};
         2'd2:    w = lo;
         default: w = hi;
      endcase
      return w;
   endfunction

endpackage

// File: rtl/pci_hdr_addr_track.sv
module pci_hdr_addr_track
   import pci_hdr_log_pkg::*;
#(
   parameter int unsigned           AD_W     = 32,
   parameter int unsigned           CBE_W    = 4,
   parameter logic [CBE_W-1:0]      DAC_CODE = CBE_W'(CMD_DUAL_ADDR)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_n,
   input  logic [AD_W-1:0]  ad,
   input  logic [CBE_W-1:0] cbe_n,
   output logic [AD_W-1:0]  sh_lo_d,
   output logic [AD_W-1:0]  sh_hi_d,
   output logic [CBE_W-1:0] sh_cl_d,
   output logic [CBE_W-1:0] sh_ch_d
);

   trk_state_t       st_q, st_d;
   logic [AD_W-1:0]  lo_q, hi_q;
   logic [CBE_W-1:0] cl_q, ch_q;

   always_comb begin
      st_d    = st_q;
      sh_lo_d = lo_q;
      sh_hi_d = hi_q;
      sh_cl_d = cl_q;
      sh_ch_d = ch_q;
      case (st_q)
         TRK_IDLE: begin
            if (!frame_n) begin
               sh_lo_d = ad;
               sh_cl_d = cbe_n;
               sh_hi_d = '0;
               sh_ch_d = '0;
               st_d    = (cbe_n == DAC_CODE) ? TRK_DAC2 : TRK_BUSY;
            end
         end
         TRK_DAC2: begin
            sh_hi_d = ad;
            sh_ch_d = cbe_n;
            st_d    = frame_n ? TRK_IDLE : TRK_BUSY;
         end
         TRK_BUSY: begin
            if (frame_n) st_d = TRK_IDLE;
         end
         default: st_d = TRK_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= TRK_IDLE;
         lo_q <= '0;
         hi_q <= '0;
         cl_q <= '0;
         ch_q <= '0;
      end else begin
         st_q <= st_d;
         lo_q <= sh_lo_d;
         hi_q <= sh_hi_d;
         cl_q <= sh_cl_d;
         ch_q <= sh_ch_d;
      end
   end

   p_first_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == TRK_IDLE && !frame_n) |=> (lo_q == $past(ad) && cl_q == $past(cbe_n)));

   p_single_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == TRK_IDLE && !frame_n && cbe_n != DAC_CODE) |=> (hi_q == '0 && ch_q == '0));

   p_second_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == TRK_DAC2) |=> (hi_q == $past(ad) && ch_q == $past(cbe_n)));

   p_no_recapture_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == TRK_BUSY) |=> ($stable(lo_q) && $stable(hi_q) && $stable(cl_q) && $stable(ch_q)));

endmodule

// File: rtl/pci_hdr_log_store.sv
module pci_hdr_log_store #(
   parameter int unsigned AD_W      = 32,
   parameter int unsigned CBE_W     = 4,
   parameter bit          VIEW_NEXT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             err_strobe,
   input  logic [AD_W-1:0]  sh_lo_d,
   input  logic [AD_W-1:0]  sh_hi_d,
   input  logic [CBE_W-1:0] sh_cl_d,
   input  logic [CBE_W-1:0] sh_ch_d,
   output logic [AD_W-1:0]  vw_lo,
   output logic [AD_W-1:0]  vw_hi,
   output logic [CBE_W-1:0] vw_cl,
   output logic [CBE_W-1:0] vw_ch
);

   logic [AD_W-1:0]  lg_lo_q, lg_hi_q, lg_lo_d, lg_hi_d;
   logic [CBE_W-1:0] lg_cl_q, lg_ch_q, lg_cl_d, lg_ch_d;

   always_comb begin
      lg_lo_d = lg_lo_q;
      lg_hi_d = lg_hi_q;
      lg_cl_d = lg_cl_q;
      lg_ch_d = lg_ch_q;
      if (err_strobe) begin
         lg_lo_d = sh_lo_d;
         lg_hi_d = sh_hi_d;
         lg_cl_d = sh_cl_d;
         lg_ch_d = sh_ch_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lg_lo_q <= '0;
         lg_hi_q <= '0;
         lg_cl_q <= '0;
         lg_ch_q <= '0;
      end else begin
         lg_lo_q <= lg_lo_d;
         lg_hi_q <= lg_hi_d;
         lg_cl_q <= lg_cl_d;
         lg_ch_q <= lg_ch_d;
      end
   end

   generate
      if (VIEW_NEXT) begin : g_view_next
         assign vw_lo = lg_lo_d;
         assign vw_hi = lg_hi_d;
         assign vw_cl = lg_cl_d;
         assign vw_ch = lg_ch_d;
      end else begin : g_view_held
         assign vw_lo = lg_lo_q;
         assign vw_hi = lg_hi_q;
         assign vw_cl = lg_cl_q;
         assign vw_ch = lg_ch_q;
      end
   endgenerate

   p_clean_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !err_strobe |=> ($stable(lg_lo_q) && $stable(lg_hi_q) && $stable(lg_cl_q) && $stable(lg_ch_q)));

   p_error_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_strobe |=> (lg_lo_q == $past(sh_lo_d) && lg_hi_q == $past(sh_hi_d)
                      && lg_cl_q == $past(sh_cl_d) && lg_ch_q == $past(sh_ch_d)));

endmodule

// File: rtl/pci_hdr_log_rdport.sv
module pci_hdr_log_rdport
   import pci_hdr_log_pkg::*;
#(
   parameter int unsigned       ADDR_W  = 10,
   parameter logic [ADDR_W-1:0] BASE_DW = ADDR_W'(10'h04F)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [31:0]       vw_lo,
   input  logic [31:0]       vw_hi,
   input  logic [3:0]        vw_cl,
   input  logic [3:0]        vw_ch,
   output logic [31:0]       rd_data
);

   localparam logic [ADDR_W-1:0] LAST_DW = BASE_DW + ADDR_W'(LOG_DWORDS - 1);

   logic [31:0]       lane [LOG_DWORDS];
   logic [ADDR_W-1:0] off;
   logic              hit;
   logic [31:0]       rd_data_d;

   generate
      for (genvar g = 0; g < LOG_DWORDS; g++) begin : g_lane
         assign lane[g] = lane_word(2'(g), vw_lo, vw_hi, vw_cl, vw_ch);
      end
   endgenerate

   assign off       = rd_addr - BASE_DW;
   assign hit       = (off < ADDR_W'(LOG_DWORDS));
   assign rd_data_d = hit ? lane[off[1:0]] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_data_d;
   end

   p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (rd_addr < BASE_DW || rd_addr > LAST_DW)) |=> (rd_data == '0));

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   p_low_dword_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == BASE_DW) |=> (rd_data == '0));

   p_fields_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == BASE_DW + ADDR_W'(1)) |=> (rd_data[31:12] == '0 && rd_data[3:0] == '0));

endmodule

// File: rtl/pci_err_hdr_log.sv
module pci_err_hdr_log
   import pci_hdr_log_pkg::*;
#(
   parameter int unsigned       AD_W        = 32,
   parameter int unsigned       CBE_W       = 4,
   parameter int unsigned       ADDR_W      = 10,
   parameter logic [ADDR_W-1:0] BASE_DW     = ADDR_W'(10'h04F),
   parameter bit                READ_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              link_rst_n,
   input  logic              glob_rst_n,
   input  logic              por_rst_n,
   input  logic              frame_n,
   input  logic [AD_W-1:0]   ad,
   input  logic [CBE_W-1:0]  cbe_n,
   input  logic              err_strobe,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data
);

   generate
      if (AD_W != 32) begin : g_bad_ad_w
         $error("pci_err_hdr_log: AD_W must be 32");
      end
      if (CBE_W != 4) begin : g_bad_cbe_w
         $error("pci_err_hdr_log: CBE_W must be 4");
      end
      if (ADDR_W < 3 || (64'(BASE_DW) + 64'(LOG_DWORDS)) > (64'd1 << ADDR_W)) begin : g_bad_base
         $error("pci_err_hdr_log: log window does not fit the read address space");
      end
   endgenerate

   logic             rst_n;
   logic [AD_W-1:0]  sh_lo_d, sh_hi_d, vw_lo, vw_hi;
   logic [CBE_W-1:0] sh_cl_d, sh_ch_d, vw_cl, vw_ch;

   assign rst_n = link_rst_n & glob_rst_n & por_rst_n;

   pci_hdr_addr_track #(
      .AD_W     (AD_W),
      .CBE_W    (CBE_W),
      .DAC_CODE (CBE_W'(CMD_DUAL_ADDR))
   ) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .frame_n (frame_n),
      .ad      (ad),
      .cbe_n   (cbe_n),
      .sh_lo_d (sh_lo_d),
      .sh_hi_d (sh_hi_d),
      .sh_cl_d (sh_cl_d),
      .sh_ch_d (sh_ch_d)
   );

   pci_hdr_log_store #(
      .AD_W      (AD_W),
      .CBE_W     (CBE_W),
      .VIEW_NEXT (READ_BYPASS)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .err_strobe (err_strobe),
      .sh_lo_d    (sh_lo_d),
      .sh_hi_d    (sh_hi_d),
      .sh_cl_d    (sh_cl_d),
      .sh_ch_d    (sh_ch_d),
      .vw_lo      (vw_lo),
      .vw_hi      (vw_hi),
      .vw_cl      (vw_cl),
      .vw_ch      (vw_ch)
   );

   pci_hdr_log_rdport #(
      .ADDR_W  (ADDR_W),
      .BASE_DW (BASE_DW)
   ) u_rdport (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .vw_lo   (vw_lo),
      .vw_hi   (vw_hi),
      .vw_cl   (vw_cl),
      .vw_ch   (vw_ch),
      .rd_data (rd_data)
   );

endmodule

// File: tb/pci_err_hdr_log_tb.sv
module pci_err_hdr_log_tb;

   localparam logic [9:0] BASE = 10'h04F;
   localparam int         WD_CYCLES = 150000;

   logic        clk = 1'b0;
   logic        link_rst_n = 1'b0, glob_rst_n = 1'b0, por_rst_n = 1'b0;
   logic        frame_n = 1'b1;
   logic [31:0] ad = '0;
   logic [3:0]  cbe_n = 4'hF;
   logic        err_strobe = 1'b0;
   logic        rd_en = 1'b0;
   logic [9:0]  rd_addr = '0;
   logic [31:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // log model
   logic [31:0] m_lo = '0, m_hi = '0;
   logic [3:0]  m_cl = '0, m_ch = '0;

   always #10 clk = ~clk;

   pci_err_hdr_log u_dut (
      .clk        (clk),
      .link_rst_n (link_rst_n),
      .glob_rst_n (glob_rst_n),
      .por_rst_n  (por_rst_n),
      .frame_n    (frame_n),
      .ad         (ad),
      .cbe_n      (cbe_n),
      .err_strobe (err_strobe),
      .rd_en      (rd_en),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data)
   );

   function automatic logic [31:0] exp_dw(input logic [9:0] a);
      logic [9:0] o;
      o = a - BASE;
      case (o)
         10'd0:   return 32'h0;
         10'd1:   return {20'h0, m_ch, m_cl, 4'h0};
         10'd2:   return m_lo;
         10'd3:   return m_hi;
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic fr, input logic [31:0] a, input logic [3:0] c, input logic e);
      @(negedge clk);
      frame_n    = fr;
      ad         = a;
      cbe_n      = c;
      err_strobe = e;
   endtask

   task automatic idle();
      drive(1'b1, 32'h0, 4'hF, 1'b0);
   endtask

   task automatic rd(input logic [9:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en   = 1'b1;
      rd_addr = a;
      frame_n = 1'b1;
      err_strobe = 1'b0;
      @(negedge clk);
      rd_en = 1'b0;
      d     = rd_data;
   endtask

   task automatic check_log(input string req);
      logic [31:0] d;
      for (int i = 0; i < 4; i++) begin
         rd(BASE + 10'(i), d);
         chk(req, d, exp_dw(BASE + 10'(i)));
      end
   endtask

   // single-address transaction; ep: 0 none, 1 strobe on address phase, 2 on data phase
   task automatic sac(input logic [31:0] a, input logic [3:0] c, input int ep);
      drive(1'b0, a, c, ep == 1);
      drive(1'b0, ~a, 4'h0, ep == 2);
      idle();
      if (ep != 0) begin
         m_lo = a; m_cl = c; m_hi = '0; m_ch = '0;
      end
   endtask

   // dual-address transaction; ep: 0 none, 1 first phase, 2 second phase, 3 data phase
   task automatic dac(input logic [31:0] a1, input logic [31:0] a2, input logic [3:0] c2, input int ep);
      drive(1'b0, a1, 4'hD, ep == 1);
      drive(1'b0, a2, c2, ep == 2);
      drive(1'b0, a1 ^ a2, 4'hD, ep == 3);
      idle();
      if (ep == 1) begin
         m_lo = a1; m_cl = 4'hD; m_hi = '0; m_ch = '0;
      end else if (ep != 0) begin
         m_lo = a1; m_cl = 4'hD; m_hi = a2; m_ch = c2;
      end
   endtask

   task automatic clear_model();
      m_lo = '0; m_hi = '0; m_cl = '0; m_ch = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] d;

      // R9: reset state
      repeat (3) @(negedge clk);
      chk("R9 reset rd_data", rd_data, 32'h0);
      link_rst_n = 1'b1; glob_rst_n = 1'b1; por_rst_n = 1'b1;
      idle();
      check_log("R9 reset log");

      // R1 R3 R4: sweep single-address commands
      for (int c = 0; c < 16; c++) begin
         if (c != 13) begin
            sac(32'h1357_9BDF * (c + 1) ^ 32'hA5A5_0000, 4'(c), 2);
            check_log("R1 R3 R4 single-address");
         end
      end

      // R2 R4: sweep dual-address second-phase commands
      for (int c = 0; c < 16; c++) begin
         dac(32'h0246_8ACE + 32'(c), 32'hF00D_0000 | 32'(c * 977), 4'(c), 3);
         check_log("R2 R4 dual-address");
      end

      // R5: clean transactions leave the log untouched
      sac(32'hDEAD_BEEF, 4'h6, 0);
      dac(32'h1111_2222, 32'h3333_4444, 4'h7, 0);
      check_log("R5 clean hold");

      // R5 R3: a single-address error replaces a dual-address entry
      sac(32'h0BAD_F00D, 4'h7, 2);
      check_log("R5 R3 overwrite");

      // R6: strobe on the address phase itself
      sac(32'h5A5A_1234, 4'h2, 1);
      check_log("R6 strobe on first phase");
      dac(32'h7777_0001, 32'h8888_0002, 4'hB, 2);
      check_log("R6 strobe on second phase");
      dac(32'h9999_0003, 32'hAAAA_0004, 4'hC, 1);
      check_log("R6 strobe on dual first phase");

      // R10: long FRAME# low burst, later values are not staged
      drive(1'b0, 32'hC0DE_0001, 4'h3, 1'b0);
      for (int k = 0; k < 5; k++) drive(1'b0, 32'hFFFF_0000 + 32'(k), 4'hD, 1'b0);
      drive(1'b0, 32'hFFFF_FFFF, 4'hD, 1'b1);
      idle();
      m_lo = 32'hC0DE_0001; m_cl = 4'h3; m_hi = '0; m_ch = '0;
      check_log("R10 no recapture in burst");

      // R10: back-to-back transaction after one idle clock
      drive(1'b0, 32'h4444_0001, 4'h7, 1'b0);
      drive(1'b1, 32'h0, 4'hF, 1'b0);
      drive(1'b0, 32'h4444_0002, 4'hA, 1'b0);
      drive(1'b0, 32'h0, 4'h0, 1'b1);
      idle();
      m_lo = 32'h4444_0002; m_cl = 4'hA;
      check_log("R10 back-to-back");

      // R7: address window sweep
      dac(32'h1234_5678, 32'h9ABC_DEF0, 4'h5, 3);
      for (int i = -8; i < 12; i++) begin
         rd(BASE + 10'(i), d);
         chk("R7 address decode", d, exp_dw(BASE + 10'(i)));
      end
      rd(10'h000, d);
      chk("R7 low edge", d, 32'h0);
      rd(10'h3FF, d);
      chk("R7 high edge", d, 32'h0);

      // R8: rd_data holds while rd_en is low
      rd(BASE + 10'd3, d);
      chk("R8 read before hold", d, 32'h9ABC_DEF0);
      sac(32'h2222_3333, 4'h6, 2);
      @(negedge clk);
      chk("R8 hold without rd_en", rd_data, 32'h9ABC_DEF0);

      // R8: read on the clock of a log update returns the new value
      drive(1'b0, 32'h6161_7272, 4'hB, 1'b0);
      @(negedge clk);
      frame_n = 1'b0; ad = 32'h0; cbe_n = 4'h0; err_strobe = 1'b1;
      rd_en = 1'b1; rd_addr = BASE + 10'd2;
      @(negedge clk);
      rd_en = 1'b0; err_strobe = 1'b0; frame_n = 1'b1;
      chk("R8 same-clock read", rd_data, 32'h6161_7272);
      m_lo = 32'h6161_7272; m_cl = 4'hB; m_hi = '0; m_ch = '0;
      check_log("R8 after bypass read");

      // R9: each reset source clears the log
      for (int s = 0; s < 3; s++) begin
         dac(32'hE0E0_0000 + 32'(s), 32'hF1F1_0000 + 32'(s), 4'h9, 3);
         rd(BASE + 10'd2, d);
         chk("R9 loaded before reset", d, 32'hE0E0_0000 + 32'(s));
         @(negedge clk);
         if (s == 0) link_rst_n = 1'b0;
         if (s == 1) glob_rst_n = 1'b0;
         if (s == 2) por_rst_n  = 1'b0;
         #1;
         chk("R9 rd_data cleared", rd_data, 32'h0);
         @(negedge clk);
         link_rst_n = 1'b1; glob_rst_n = 1'b1; por_rst_n = 1'b1;
         clear_model();
         check_log("R9 log cleared");
      end

      finish_run();
   end

endmodule